// File: doc/BRIEF.md
# Burst Mode Transmit Controller

This block steers the transmit path of a burst-mode upstream PCS. It receives a delayed stream of XGMII codes along with a level that reports whether real traffic is waiting. From these it decides, group by group, what goes toward the gearbox. Codes are taken in groups of four, and each completed group yields one 66-bit word.

While the transmitter is locking, the block replaces normal encoding with synthetic words. During clock recovery it emits an alternating sync word and raises a laser-on request whenever traffic is waiting. A fixed number of sync words after traffic appears, it emits a single delimiter word. In the same cycle it pulses a reset to the rate adaptation, 64b/66b encoder, scrambler and FEC encoder. It then hands every later code to that data path until traffic stops. When traffic stops, it falls back to clock-recovery mode for the next burst.

Top module: `burst_tx_ctrl`

## Requirements
- R1: After reset the block is in clock-recovery mode with its code-group count at zero, and all of `word_valid`, `dp_rst`, `fwd_valid` and `laser_on` are low.
- R2: In clock-recovery and framing modes, every fourth accepted code (a cycle with `code_valid` high) produces `word_valid` high for one cycle, in the cycle after that code.
- R3: A word produced in clock-recovery mode has bit i equal to 1 for even i and 0 for odd i, across all 66 bits.
- R4: `laser_on` is high in the cycle after each cycle in clock-recovery mode with `pending` high, and low in every other cycle.
- R5: In clock-recovery mode the block counts words emitted while `pending` is high. Any cycle with `pending` low clears the count. The word that brings the count to `SYNC_WORDS` is still a sync word, and the block enters framing mode right after it.
- R6: In framing mode the fourth accepted code produces the word `DELIM`. `dp_rst` is high for exactly that one cycle, together with `word_valid`, and the block then enters data mode.
- R7: In data mode each accepted code appears on `fwd_code` with `fwd_valid` high one cycle later, and no word is emitted.
- R8: In data mode a cycle with `pending` low returns the block to clock-recovery mode. A code offered in that cycle is not forwarded, and code grouping restarts from zero.
- R9: Cycles with `code_valid` low advance nothing: they produce no word and no forwarded code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | A dequeued code is offered this cycle |
| code_in | input | CODE_W | Dequeued code (control flag plus octet) |
| pending | input | 1 | Traffic waiting in the delay line (level) |
| word_valid | output | 1 | A 66-bit word is presented on word_data |
| word_data | output | 66 | Sync or delimiter word toward the gearbox |
| dp_rst | output | 1 | One-cycle reset to rate adaptation, encoder, scrambler, FEC |
| fwd_valid | output | 1 | A code is presented to the data path |
| fwd_code | output | CODE_W | Code forwarded to the data path |
| laser_on | output | 1 | Laser-on request |

## Verification
The assertions assume that `pending` changes only between clock edges and that reset is held for at least one edge before traffic starts. They also assume `DELIM` differs from the sync word, so that a delimiter can be told apart from sync by value. The stimulus drives every input at the falling edge and uses a delimiter distinct from the alternating pattern. It sweeps the phase at which `pending` rises within a code group, the spacing of idle cycles and the burst length. It also withdraws `pending` before the sync time ends, to show that the count restarts.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;

    localparam int WORD_W = 66;

    typedef enum logic [1:0] {
        PH_CDR   = 2'd0,
        PH_FRAME = 2'd1,
        PH_DATA  = 2'd2
    } phase_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } word_t;

    // Alternating pattern, ones on even bit positions.
    function automatic logic [WORD_W-1:0] alt_pattern();
        logic [WORD_W-1:0] w;
        for (int i = 0; i < WORD_W; i++) begin
            w[i] = (i % 2 == 0);
        end
        return w;
    endfunction

endpackage

// File: rtl/btc_grouper.sv
module btc_grouper #(
    parameter int GROUP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic last
);
    localparam int CW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [CW-1:0] TOP = CW'(GROUP - 1);

    logic [CW-1:0] cnt;

    assign last = adv && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/btc_sync_timer.sv
module btc_sync_timer #(
    parameter int SYNC_WORDS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic tick,
    output logic done
);
    localparam int CW = (SYNC_WORDS > 1) ? $clog2(SYNC_WORDS) : 1;
    localparam logic [CW-1:0] TOP = CW'(SYNC_WORDS - 1);

    logic [CW-1:0] cnt;

    assign done = tick && pending && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst || !pending || done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/burst_tx_ctrl.sv
module burst_tx_ctrl
    import burst_tx_pkg::*;
#(
    parameter int                CODE_W     = 9,
    parameter int                GROUP      = 4,
    parameter int                SYNC_WORDS = 8,
    parameter logic [WORD_W-1:0] DELIM      = 66'h1_F2E3_4A5B_6C7D_8E90
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_in,
    input  logic              pending,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              dp_rst,
    output logic              fwd_valid,
    output logic [CODE_W-1:0] fwd_code,
    output logic              laser_on
);
    localparam logic [WORD_W-1:0] SYNC = alt_pattern();

    phase_t phase, phase_nx;
    logic   grp_last, sync_done, in_data;
    word_t  word_q;

    assign in_data = (phase == PH_DATA);

    btc_grouper #(.GROUP(GROUP)) u_grp (
        .clk  (clk),
        .rst  (rst),
        .clr  (in_data),
        .adv  (code_valid && !in_data),
        .last (grp_last)
    );

    btc_sync_timer #(.SYNC_WORDS(SYNC_WORDS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .tick    (grp_last && phase == PH_CDR),
        .done    (sync_done)
    );

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_CDR:   if (sync_done) phase_nx = PH_FRAME;
            PH_FRAME: if (grp_last)  phase_nx = PH_DATA;
            PH_DATA:  if (!pending)  phase_nx = PH_CDR;
            default:                 phase_nx = PH_CDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CDR;
            word_q    <= '0;
            dp_rst    <= 1'b0;
            fwd_valid <= 1'b0;
            fwd_code  <= '0;
            laser_on  <= 1'b0;
        end else begin
            phase        <= phase_nx;
            word_q.valid <= grp_last;
            if (grp_last) begin
                word_q.data <= (phase == PH_FRAME) ? DELIM : SYNC;
            end
            dp_rst    <= grp_last && (phase == PH_FRAME);
            fwd_valid <= in_data && pending && code_valid;
            if (in_data && code_valid) begin
                fwd_code <= code_in;
            end
            laser_on  <= (phase == PH_CDR) && pending;
        end
    end

    assign word_valid = word_q.valid;
    assign word_data  = word_q.data;
endmodule

// File: rtl/burst_tx_chk.sv
module burst_tx_chk
    import burst_tx_pkg::*;
#(
    parameter int                CODE_W = 9,
    parameter logic [WORD_W-1:0] DELIM  = 66'h1_F2E3_4A5B_6C7D_8E90
) (
    input logic              clk,
    input logic              rst,
    input logic              code_valid,
    input logic [CODE_W-1:0] code_in,
    input logic              pending,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data,
    input logic              dp_rst,
    input logic              fwd_valid,
    input logic [CODE_W-1:0] fwd_code,
    input logic              laser_on
);
    localparam logic [WORD_W-1:0] SYNC = alt_pattern();

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        dp_rst |=> !dp_rst); // R6
    AST_RST_ON_DELIM: assert property (@(posedge clk) disable iff (rst)
        dp_rst |-> (word_valid && word_data == DELIM)); // R6
    AST_WORD_OR_FWD: assert property (@(posedge clk) disable iff (rst)
        !(word_valid && fwd_valid)); // R7
    AST_WORD_AFTER_CODE: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(code_valid)); // R2
    AST_FWD_MATCH: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> ($past(code_valid) && fwd_code == $past(code_in))); // R7
    AST_SYNC_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !dp_rst) |-> word_data == SYNC); // R3
    AST_LASER_PENDING: assert property (@(posedge clk) disable iff (rst)
        laser_on |-> $past(pending)); // R4
endmodule

bind burst_tx_ctrl burst_tx_chk #(.CODE_W(CODE_W), .DELIM(DELIM)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .code_valid (code_valid),
    .code_in    (code_in),
    .pending    (pending),
    .word_valid (word_valid),
    .word_data  (word_data),
    .dp_rst     (dp_rst),
    .fwd_valid  (fwd_valid),
    .fwd_code   (fwd_code),
    .laser_on   (laser_on)
);

// File: tb/tb_burst_tx_ctrl.sv
module tb_burst_tx_ctrl;
    localparam int CODE_W = 9;
    localparam int SYNC_N = 3;
    localparam logic [65:0] DELIM = 66'h2_9C3B_0F17_A4D2_6E85;

    localparam int K_NONE  = 0;
    localparam int K_SYNC  = 1;
    localparam int K_DELIM = 2;
    localparam int K_FWD   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              code_valid = 1'b0;
    logic [CODE_W-1:0] code_in = '0;
    logic              pending = 1'b0;
    logic              word_valid, dp_rst, fwd_valid, laser_on;
    logic [65:0]       word_data;
    logic [CODE_W-1:0] fwd_code;

    int checks = 0;
    int errors = 0;
    logic [65:0] sync_exp;

    int          pk = K_NONE;
    logic        pl = 1'b0;
    logic [CODE_W-1:0] pc = '0;
    string       ptag = "R1";
    logic [CODE_W-1:0] seq = 9'd1;

    always #2 clk = ~clk;

    burst_tx_ctrl #(.CODE_W(CODE_W), .SYNC_WORDS(SYNC_N), .DELIM(DELIM)) dut (
        .clk(clk), .rst(rst), .code_valid(code_valid), .code_in(code_in),
        .pending(pending), .word_valid(word_valid), .word_data(word_data),
        .dp_rst(dp_rst), .fwd_valid(fwd_valid), .fwd_code(fwd_code),
        .laser_on(laser_on)
    );

    task automatic chk(input string tag, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Checks the previous cycle's expectations, then drives the next cycle.
    task automatic step(input logic v, input logic p, input int kind,
                        input logic las, input string tag);
        @(negedge clk);
        chk({ptag, " word_valid"}, 66'(word_valid), 66'(pk == K_SYNC || pk == K_DELIM));
        if (pk == K_SYNC)  chk({ptag, " R3 sync word"}, word_data, sync_exp);
        if (pk == K_DELIM) chk({ptag, " R6 delimiter"}, word_data, DELIM);
        chk({ptag, " R6 dp_rst"}, 66'(dp_rst), 66'(pk == K_DELIM));
        chk({ptag, " R7 fwd_valid"}, 66'(fwd_valid), 66'(pk == K_FWD));
        if (pk == K_FWD) chk({ptag, " R7 fwd_code"}, 66'(fwd_code), 66'(pc));
        chk({ptag, " R4 laser_on"}, 66'(laser_on), 66'(pl));
        code_valid = v;
        pending    = p;
        code_in    = v ? seq : 9'h1FF;
        pc   = code_in;
        pk   = kind;
        pl   = las;
        ptag = tag;
        if (v) seq = seq + 9'd7;
    endtask

    // One burst: pre-rise codes, then rise at offset off inside a group.
    task automatic run_burst(input int pre, input int off, input int gap, input int dlen);
        int f, t1, t2, c;
        f  = (off == 0) ? 4 : 4 - off;
        t1 = f + 4 * (SYNC_N - 1);
        t2 = f + 4 * SYNC_N;
        for (int i = 1; i <= 4 * pre + off; i++) begin
            step(1'b1, 1'b0, (i % 4 == 0) ? K_SYNC : K_NONE, 1'b0, "R2");
        end
        c = 0;
        for (int k = 1; k <= t2 + dlen; k++) begin
            if (gap != 0 && k % gap == 0) begin
                step(1'b0, 1'b1, K_NONE, c < t1, "R9");
            end
            if (k > t2)
                step(1'b1, 1'b1, K_FWD, 1'b0, "R7");
            else if (k == t2)
                step(1'b1, 1'b1, K_DELIM, 1'b0, "R6");
            else
                step(1'b1, 1'b1, (k >= f && (k - f) % 4 == 0) ? K_SYNC : K_NONE,
                     c < t1, "R5");
            c++;
        end
        step(1'b1, 1'b0, K_NONE, 1'b0, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 66; i++) sync_exp[i] = (i % 2 == 0);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 word_valid", 66'(word_valid), 66'd0);
        chk("R1 dp_rst",     66'(dp_rst),     66'd0);
        chk("R1 fwd_valid",  66'(fwd_valid),  66'd0);
        chk("R1 laser_on",   66'(laser_on),   66'd0);
        rst = 1'b0;
        // R5: pending withdrawn before sync time ends clears the count
        for (int i = 1; i <= 4 * (SYNC_N - 1); i++)
            step(1'b1, 1'b1, (i % 4 == 0) ? K_SYNC : K_NONE, 1'b1, "R5");
        for (int i = 1; i <= 4; i++)
            step(1'b1, 1'b0, (i % 4 == 0) ? K_SYNC : K_NONE, 1'b0, "R5");
        run_burst(0, 0, 0, 2);
        // Sweep rise offset, idle spacing and burst length
        for (int off = 0; off < 4; off++)
            for (int gap = 0; gap <= 3; gap += 3)
                for (int d = 1; d <= 2; d++)
                    run_burst(1, off, gap, d);
        step(1'b0, 1'b0, K_NONE, 1'b0, "R8");
        step(1'b0, 1'b0, K_NONE, 1'b0, "R8");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule